// File: doc/BRIEF.md
# System Bus Address Decoder with Per-Master Visibility

This block sits at the slave side of a small SoC interconnect. Each request brings a 32-bit byte address, a write flag and the identity of the master issuing it: the processor, the signal processor, the DMA engine or the display controller. The block answers with a one-hot slave select, the byte offset inside the selected slave, or a bus error. All masters share the same physical map, so no master needs address translation.

The 4 GB space is split into eight equal regions by the top three address bits. The first DRAM bank holds a small memory whose upper address bits are left undecoded, so its contents repeat across the whole region. The fast peripheral region is cut into fixed register windows. Any access that lands in an empty window, that targets a slave the master may not see, or that writes a ROM gets an error instead of a select.

Requests are accepted every cycle. The response is registered and appears exactly one cycle after acceptance.

Top module: `sys_addr_decoder`

## Requirements
- R1: Address bits [31:29] choose the region. Values 0 to 7 map to boot ROM, second ROM, signal processor, fast peripherals, slow peripherals, internal RAM, DRAM bank 0 and DRAM bank 1. The select bits are ROM0=0, ROM1=1, signal processor=2, fast windows=3..6, slow bus=7, internal RAM=8, DRAM0=9, DRAM1=10. At most one select bit is high.
- R2: DRAM bank 0 holds 32 MB and ignores address bits [28:25]. Its offset is address[24:0] zero-extended, so each of the sixteen 32 MB slices of the region reaches the same memory.
- R3: The fast region is split into 64 KB windows indexed by address[28:16]. Index 0 selects NAND (bit 3), 1 selects inter-processor messaging (bit 4), 2 selects audio (bit 5) and 3 selects USB (bit 6). The offset is address[15:0]. Any other index is a bus error.
- R4: An error response has rsp_err=1, all select bits 0 and offset 0. A successful response has rsp_err=0 and exactly one select bit set.
- R5: Master codes are 0=processor, 1=signal processor, 2=DMA and 3=display. The processor may reach every slave.
- R6: The display master may reach only DRAM0 and DRAM1. Any other target is an error.
- R7: The DMA master may reach DRAM0, DRAM1 and the four fast windows. Any other target is an error.
- R8: The signal processor master may reach DRAM0, DRAM1, internal RAM and its own region. Any other target is an error.
- R9: A write (req_write=1) to either ROM region is an error. A read of a ROM region is allowed to masters that can see it.
- R10: req_ready is 1 whenever reset is low. A request accepted at a clock edge produces rsp_valid=1 with its result after the next edge, and back-to-back requests give back-to-back responses. A cycle with no accepted request gives rsp_valid=0, rsp_err=0, selects 0 and offset 0.
- R11: A synchronous active-high reset clears rsp_valid, rsp_err, the offset and all select lines, and holds req_ready low.
- R12: In every region other than DRAM0 and the fast windows, the offset is address[28:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | 32 | Byte address |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_master | input | 2 | Issuing master code |
| rsp_valid | output | 1 | Response present |
| rsp_sel | output | 11 | One-hot slave select |
| rsp_offset | output | 32 | Offset inside the selected slave |
| rsp_err | output | 1 | Bus error |

## Verification
Every result is due exactly one clock edge after the request is accepted. The bench drives a request on a falling edge and reads select, offset and error on the following falling edge, after the single register has loaded. Back-to-back requests are checked at successive falling edges. The idle response is checked on the falling edge that follows the withdrawal of the request. Reset effects are checked one edge after reset is raised.

// File: rtl/addr_dec_pkg.sv
package addr_dec_pkg;
    localparam int ADDR_W      = 32;
    localparam int REGION_LSB  = 29;
    localparam int N_FAST      = 4;

    localparam int SLV_ROM0    = 0;
    localparam int SLV_ROM1    = 1;
    localparam int SLV_DSP     = 2;
    localparam int SLV_FAST0   = 3;
    localparam int SLV_SLOW    = SLV_FAST0 + N_FAST;
    localparam int SLV_IRAM    = SLV_SLOW + 1;
    localparam int SLV_DRAM0   = SLV_IRAM + 1;
    localparam int SLV_DRAM1   = SLV_DRAM0 + 1;
    localparam int N_SLV       = SLV_DRAM1 + 1;

    typedef enum logic [1:0] {
        MST_CPU  = 2'd0,
        MST_DSP  = 2'd1,
        MST_DMA  = 2'd2,
        MST_DISP = 2'd3
    } master_e;

    typedef struct packed {
        logic              valid;
        logic [N_SLV-1:0]  sel;
        logic [ADDR_W-1:0] offset;
        logic              err;
    } rsp_t;

    function automatic logic [N_SLV-1:0] one_slave(input int idx);
        logic [N_SLV-1:0] m;
        m = '0;
        m[idx] = 1'b1;
        return m;
    endfunction

    function automatic logic [N_SLV-1:0] fast_set();
        logic [N_SLV-1:0] m;
        m = '0;
        for (int k = 0; k < N_FAST; k++) m[SLV_FAST0 + k] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/region_decode.sv
module region_decode
    import addr_dec_pkg::*;
#(
    parameter int DRAM0_LOG2 = 25,
    parameter int WIN_LOG2   = 16
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [N_SLV-1:0]  hit,
    output logic [ADDR_W-1:0] offset,
    output logic              unmapped
);
    localparam int IDX_W = REGION_LSB - WIN_LOG2;
    localparam logic [ADDR_W-1:0] REGION_MASK = (ADDR_W'(1) << REGION_LSB) - 1;
    localparam logic [ADDR_W-1:0] DRAM0_MASK  = (ADDR_W'(1) << DRAM0_LOG2) - 1;
    localparam logic [ADDR_W-1:0] WIN_MASK    = (ADDR_W'(1) << WIN_LOG2) - 1;

    logic [IDX_W-1:0]  win_idx;
    logic [N_FAST-1:0] fast_hit;

    assign win_idx = addr[REGION_LSB-1:WIN_LOG2];

    for (genvar k = 0; k < N_FAST; k++) begin : g_win
        assign fast_hit[k] = (win_idx == IDX_W'(k));
    end

    always_comb begin
        hit      = '0;
        offset   = addr & REGION_MASK;
        unmapped = 1'b0;
        case (addr[ADDR_W-1:REGION_LSB])
            3'd0: hit[SLV_ROM0]  = 1'b1;
            3'd1: hit[SLV_ROM1]  = 1'b1;
            3'd2: hit[SLV_DSP]   = 1'b1;
            3'd3: begin
                hit[SLV_FAST0 +: N_FAST] = fast_hit;
                offset   = addr & WIN_MASK;
                unmapped = ~|fast_hit;
            end
            3'd4: hit[SLV_SLOW]  = 1'b1;
            3'd5: hit[SLV_IRAM]  = 1'b1;
            3'd6: begin
                hit[SLV_DRAM0] = 1'b1;
                offset = addr & DRAM0_MASK;
            end
            default: hit[SLV_DRAM1] = 1'b1;
        endcase
    end
endmodule

// File: rtl/access_filter.sv
module access_filter
    import addr_dec_pkg::*;
(
    input  master_e          master,
    input  logic             write,
    input  logic [N_SLV-1:0] hit,
    output logic             allowed
);
    localparam logic [N_SLV-1:0] SET_DRAM = one_slave(SLV_DRAM0) | one_slave(SLV_DRAM1);
    localparam logic [N_SLV-1:0] SET_ROM  = one_slave(SLV_ROM0) | one_slave(SLV_ROM1);

    logic [N_SLV-1:0] vis;
    logic             rom_write;

    always_comb begin
        case (master)
            MST_CPU:  vis = '1;
            MST_DSP:  vis = SET_DRAM | one_slave(SLV_IRAM) | one_slave(SLV_DSP);
            MST_DMA:  vis = SET_DRAM | fast_set();
            default:  vis = SET_DRAM;
        endcase
        rom_write = write && |(hit & SET_ROM);
        allowed   = |(hit & vis) && !rom_write;
    end
endmodule

// File: rtl/sys_addr_decoder.sv
module sys_addr_decoder
    import addr_dec_pkg::*;
#(
    parameter int DRAM0_LOG2 = 25,
    parameter int WIN_LOG2   = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [31:0]       req_addr,
    input  logic              req_write,
    input  logic [1:0]        req_master,
    output logic              rsp_valid,
    output logic [10:0]       rsp_sel,
    output logic [31:0]       rsp_offset,
    output logic              rsp_err
);
    logic [N_SLV-1:0]  hit;
    logic [ADDR_W-1:0] off;
    logic              unmapped;
    logic              allowed;
    logic              accept;
    rsp_t              rsp_d, rsp_q;

    region_decode #(
        .DRAM0_LOG2(DRAM0_LOG2),
        .WIN_LOG2  (WIN_LOG2)
    ) u_region (
        .addr    (req_addr),
        .hit     (hit),
        .offset  (off),
        .unmapped(unmapped)
    );

    access_filter u_filter (
        .master (master_e'(req_master)),
        .write  (req_write),
        .hit    (hit),
        .allowed(allowed)
    );

    assign req_ready = !rst;
    assign accept    = req_valid && req_ready;

    always_comb begin
        rsp_d = '0;
        if (accept) begin
            rsp_d.valid = 1'b1;
            if (!unmapped && allowed) begin
                rsp_d.sel    = hit;
                rsp_d.offset = off;
            end else begin
                rsp_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rsp_q <= '0;
        else     rsp_q <= rsp_d;
    end

    assign rsp_valid  = rsp_q.valid;
    assign rsp_sel    = rsp_q.sel;
    assign rsp_offset = rsp_q.offset;
    assign rsp_err    = rsp_q.err;
endmodule

module sys_addr_decoder_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic [31:0] req_addr,
    input logic        req_write,
    input logic [1:0]  req_master,
    input logic        rsp_valid,
    input logic [10:0] rsp_sel,
    input logic [31:0] rsp_offset,
    input logic        rsp_err
);
    logic acc;
    assign acc = req_valid && req_ready;

    assert_sel_onehot_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rsp_sel));

    assert_dram_alias_R2: assert property (@(posedge clk) disable iff (rst)
        (acc && req_master == 2'd0 && req_addr[31:29] == 3'd6)
        |=> (rsp_sel[9] && rsp_offset == {7'd0, $past(req_addr[24:0])}));

    assert_err_clean_R4: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> (rsp_sel == '0 && rsp_offset == '0 && rsp_valid));

    assert_ok_sel_R4: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_err) |-> $countones(rsp_sel) == 1);

    assert_disp_dram_R6: assert property (@(posedge clk) disable iff (rst)
        (acc && req_master == 2'd3) |=> (rsp_sel[8:0] == '0));

    assert_rom_write_R9: assert property (@(posedge clk) disable iff (rst)
        (acc && req_write && req_addr[31:30] == 2'b00) |=> rsp_err);

    assert_next_cycle_R10: assert property (@(posedge clk) disable iff (rst)
        acc |=> rsp_valid);

    assert_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !acc |=> (!rsp_valid && !rsp_err && rsp_sel == '0));

    assert_reset_R11: assert property (@(posedge clk)
        rst |=> (!rsp_valid && rsp_sel == '0 && !rsp_err));
endmodule

bind sys_addr_decoder sys_addr_decoder_chk u_chk (.*);

// File: tb/sys_addr_decoder_test.sv
`timescale 1ns/1ps
module sys_addr_decoder_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic        req_ready;
    logic [31:0] req_addr;
    logic        req_write;
    logic [1:0]  req_master;
    logic        rsp_valid;
    logic [10:0] rsp_sel;
    logic [31:0] rsp_offset;
    logic        rsp_err;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    localparam logic [1:0] CPU = 2'd0, DSP = 2'd1, DMA = 2'd2, DISP = 2'd3;

    always #2.5 clk = ~clk;

    sys_addr_decoder uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write), .req_master(req_master),
        .rsp_valid(rsp_valid), .rsp_sel(rsp_sel), .rsp_offset(rsp_offset),
        .rsp_err(rsp_err)
    );

    function automatic logic [10:0] bit_of(input int i);
        return 11'(1) << i;
    endfunction

    task automatic expect_rsp(input string tag, input logic v, input logic [10:0] sel,
                              input logic [31:0] off, input logic err);
        checks++;
        if (rsp_valid !== v || rsp_sel !== sel || rsp_offset !== off || rsp_err !== err) begin
            errors++;
            $display("FAIL %s: got v=%b sel=%h off=%h err=%b, expected v=%b sel=%h off=%h err=%b",
                     tag, rsp_valid, rsp_sel, rsp_offset, rsp_err, v, sel, off, err);
        end
    endtask

    task automatic drive(input logic [1:0] m, input logic w, input logic [31:0] a);
        req_valid  = 1'b1;
        req_master = m;
        req_write  = w;
        req_addr   = a;
    endtask

    task automatic one(input string tag, input logic [1:0] m, input logic w,
                       input logic [31:0] a, input logic [10:0] sel,
                       input logic [31:0] off, input logic err);
        @(negedge clk);
        drive(m, w, a);
        @(negedge clk);
        req_valid = 1'b0;
        expect_rsp(tag, 1'b1, sel, off, err);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        drive(CPU, 1'b0, 32'hC000_0000);
        repeat (3) @(negedge clk);
        checks++;
        if (req_ready !== 1'b0) begin
            errors++;
            $display("FAIL R11: req_ready=%b expected 0", req_ready);
        end
        expect_rsp("R11 reset state", 1'b0, '0, '0, 1'b0);
        rst = 1'b0;
        req_valid = 1'b0;
        @(negedge clk);
        checks++;
        if (req_ready !== 1'b1) begin
            errors++;
            $display("FAIL R10: req_ready=%b expected 1", req_ready);
        end
    endtask

    task automatic t_cpu_regions();
        one("R1 R12 rom0",   CPU, 0, 32'h0000_1234, bit_of(0),  32'h0000_1234, 0);
        one("R1 R12 rom1",   CPU, 0, 32'h2000_0010, bit_of(1),  32'h0000_0010, 0);
        one("R1 R12 dsp",    CPU, 0, 32'h4ABC_0000, bit_of(2),  32'h0ABC_0000, 0);
        one("R1 R12 slow",   CPU, 1, 32'h8123_4567, bit_of(7),  32'h0123_4567, 0);
        one("R1 R12 iram",   CPU, 1, 32'hA000_0100, bit_of(8),  32'h0000_0100, 0);
        one("R1 R12 dram1",  CPU, 0, 32'hE100_0000, bit_of(10), 32'h0100_0000, 0);
        one("R5 cpu write dram", CPU, 1, 32'hC000_0040, bit_of(9), 32'h0000_0040, 0);
    endtask

    task automatic t_dram_alias();
        one("R2 base",     CPU, 0, 32'hC000_0040, bit_of(9), 32'h0000_0040, 0);
        one("R2 alias 1",  CPU, 0, 32'hC200_0040, bit_of(9), 32'h0000_0040, 0);
        one("R2 alias F",  CPU, 0, 32'hDFFF_FFFC, bit_of(9), 32'h01FF_FFFC, 0);
    endtask

    task automatic t_fast_windows();
        one("R3 nand",     CPU, 0, 32'h6000_0004, bit_of(3), 32'h0000_0004, 0);
        one("R3 ipc",      CPU, 0, 32'h6001_FFFC, bit_of(4), 32'h0000_FFFC, 0);
        one("R3 audio",    CPU, 0, 32'h6002_0000, bit_of(5), 32'h0000_0000, 0);
        one("R3 usb",      CPU, 1, 32'h6003_1234, bit_of(6), 32'h0000_1234, 0);
        one("R3 R4 empty", CPU, 0, 32'h6004_0000, '0, '0, 1);
        one("R3 R4 top",   CPU, 0, 32'h7FFF_FFFC, '0, '0, 1);
    endtask

    task automatic t_rom_write();
        one("R9 rom0 write", CPU, 1, 32'h0000_0000, '0, '0, 1);
        one("R9 rom1 write", CPU, 1, 32'h3FFF_FFF0, '0, '0, 1);
    endtask

    task automatic t_display();
        one("R6 disp dram0", DISP, 0, 32'hC400_0010, bit_of(9),  32'h0000_0010, 0);
        one("R6 disp dram1", DISP, 0, 32'hE000_0020, bit_of(10), 32'h0000_0020, 0);
        one("R6 disp iram",  DISP, 0, 32'hA000_0000, '0, '0, 1);
        one("R6 disp fast",  DISP, 0, 32'h6000_0000, '0, '0, 1);
    endtask

    task automatic t_dma();
        one("R7 dma dram",   DMA, 1, 32'hC000_0100, bit_of(9), 32'h0000_0100, 0);
        one("R7 dma usb",    DMA, 0, 32'h6003_0008, bit_of(6), 32'h0000_0008, 0);
        one("R7 dma slow",   DMA, 0, 32'h8000_0000, '0, '0, 1);
        one("R7 dma rom",    DMA, 0, 32'h0000_0100, '0, '0, 1);
        one("R7 dma empty",  DMA, 0, 32'h6010_0000, '0, '0, 1);
    endtask

    task automatic t_dsp();
        one("R8 dsp own",   DSP, 0, 32'h4000_0080, bit_of(2), 32'h0000_0080, 0);
        one("R8 dsp iram",  DSP, 1, 32'hA000_0200, bit_of(8), 32'h0000_0200, 0);
        one("R8 dsp dram",  DSP, 0, 32'hE000_0004, bit_of(10), 32'h0000_0004, 0);
        one("R8 dsp fast",  DSP, 0, 32'h6002_0000, '0, '0, 1);
        one("R8 dsp slow",  DSP, 0, 32'h8000_0010, '0, '0, 1);
    endtask

    task automatic t_back_to_back();
        @(negedge clk);
        drive(CPU, 0, 32'h6001_0010);
        @(negedge clk);
        expect_rsp("R10 first", 1'b1, bit_of(4), 32'h0000_0010, 0);
        drive(DISP, 0, 32'h8000_0000);
        @(negedge clk);
        expect_rsp("R10 second", 1'b1, '0, '0, 1);
        drive(CPU, 0, 32'hA000_0008);
        @(negedge clk);
        req_valid = 1'b0;
        expect_rsp("R10 third", 1'b1, bit_of(8), 32'h0000_0008, 0);
        @(negedge clk);
        expect_rsp("R10 idle", 1'b0, '0, '0, 0);
    endtask

    task automatic t_mid_reset();
        @(negedge clk);
        drive(CPU, 0, 32'hC000_0000);
        @(negedge clk);
        expect_rsp("R11 before reset", 1'b1, bit_of(9), '0, 0);
        rst = 1'b1;
        @(negedge clk);
        expect_rsp("R11 cleared", 1'b0, '0, '0, 0);
        rst = 1'b0;
        req_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        req_valid = 0; req_addr = '0; req_write = 0; req_master = CPU; rst = 1;
        t_reset();
        t_cpu_regions();
        t_dram_alias();
        t_fast_windows();
        t_rom_write();
        t_display();
        t_dma();
        t_dsp();
        t_back_to_back();
        t_mid_reset();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule